// File: doc/BRIEF.md
# Region-Based Access Permission Checker

This block judges one bus access per cycle against a bank of protection regions and a few global control bits. Each region is a naturally aligned power-of-two window of memory. It carries an enable, an eight-way subregion disable mask, a three-bit permission code, an execute-never bit and a set of memory attribute bits. The checker does not interpret the attribute bits. It passes them through from whichever region decides the access.

The allow decision, the deciding region index and a no-match indicator are combinational from the access inputs. Every strobed access that is denied raises a registered fault flag one cycle later. The region index, or a no-match indication, is captured with it. When no enabled region matches, an optional background map grants privileged accesses only. Protection can be bypassed globally, and it can also be bypassed while a high-priority fault handler runs.

Top module: `mpu_access_check`

## Requirements
- R1: Region i covers 2^(SIZE+1) bytes starting at its base. Only address bits at and above SIZE+1 are compared with the stored base. SIZE 31 covers the whole 32-bit space, whatever the stored base.
- R2: A region whose SIZE is below 4 never matches.
- R3: A region is split into eight equal eighths. Eighth k is addressed by the three offset bits just below bit SIZE+1. When mask bit k is set, that eighth does not match. For SIZE 6 or less (128 bytes or smaller), the mask is ignored.
- R4: The permission code in each region decodes as follows:
  - 0 and 4: nothing is allowed.
  - 1: privileged read and write; unprivileged access is denied.
  - 2: privileged read and write; unprivileged read only.
  - 3: everything is allowed.
  - 5: privileged read only; unprivileged access is denied.
  - 6 and 7: read only at both levels.
  
  An instruction fetch is judged as a read.
- R5: An instruction fetch that hits a region with execute-never set is denied, whatever the permission code.
- R6: When several enabled regions match, the highest-numbered one decides. Its index drives `hit_idx_o` and its attribute bits drive `attr_o`. With no match, `no_hit_o` is 1 and `hit_idx_o` and `attr_o` are 0.
- R7: With protection on and no region matched, the result depends on the background bit:
  - Background bit clear: every access is denied.
  - Background bit set: privileged accesses are allowed and unprivileged accesses are denied.
  
  A matching region always overrides the background map.
- R8: With the global protection enable clear, every access is allowed.
- R9: An access flagged as coming from a fault handler is allowed when the handler-enable bit is clear. When that bit is set, the access is checked normally.
- R10: The cycle after a denied access with `acc_valid_i` high, `fault_o` is 1. `fault_idx_o` and `fault_no_hit_o` then hold the region index and the no-match state of that access, and they keep those values until the next fault. A denied access without the strobe raises no fault.
- R11: After reset, `fault_o`, `fault_idx_o` and `fault_no_hit_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| prot_en_i | input | 1 | Global protection enable |
| bg_en_i | input | 1 | Privileged background map enable |
| handler_en_i | input | 1 | Keep protection active inside fault handlers |
| region_en_i | input | NUM_REGIONS | Per-region enable |
| region_base_i | input | NUM_REGIONS*ADDR_W | Per-region base address, region i at slice i |
| region_size_i | input | NUM_REGIONS*5 | Per-region size code |
| region_srd_i | input | NUM_REGIONS*8 | Per-region subregion disable mask |
| region_perm_i | input | NUM_REGIONS*3 | Per-region permission code |
| region_xn_i | input | NUM_REGIONS | Per-region execute-never |
| region_attr_i | input | NUM_REGIONS*6 | Per-region pass-through memory attributes |
| acc_valid_i | input | 1 | Access strobe |
| acc_addr_i | input | ADDR_W | Access address |
| acc_write_i | input | 1 | 1 = write, 0 = read |
| acc_fetch_i | input | 1 | Instruction fetch |
| acc_priv_i | input | 1 | Privileged access |
| acc_in_handler_i | input | 1 | Access issued by a high-priority fault handler |
| allow_o | output | 1 | Access allowed (combinational) |
| hit_idx_o | output | $clog2(NUM_REGIONS) | Deciding region index |
| no_hit_o | output | 1 | No enabled region matched |
| attr_o | output | 6 | Attributes of the deciding region |
| fault_o | output | 1 | Registered fault pulse |
| fault_idx_o | output | $clog2(NUM_REGIONS) | Region index captured with the last fault |
| fault_no_hit_o | output | 1 | No-match state captured with the last fault |

## Verification
The bench builds the block with its defaults: eight regions and a 32-bit address. At those values the full-space SIZE 31 case is reachable. So are priority across all eight slots, including the top slot overriding every other region.

With this size, every permission code can be placed in its own region at the same time. Overlapping regions, a disabled eighth inside a 256 KB region, an ignored mask on a 128-byte region and an illegal 16-byte region all coexist. One table walk can therefore cross all of them without reprogramming.

// File: rtl/mpu_chk_pkg.sv
package mpu_chk_pkg;
  localparam int SIZE_W = 5;
  localparam int SRD_W  = 8;
  localparam int PERM_W = 3;
  localparam int ATTR_W = 6;
  localparam logic [SIZE_W-1:0] MIN_SIZE  = 5'd4;
  localparam logic [SIZE_W-1:0] SUBR_SIZE = 5'd7;

  typedef enum logic [PERM_W-1:0] {
    PERM_NONE    = 3'd0,
    PERM_PRW     = 3'd1,
    PERM_PRW_URO = 3'd2,
    PERM_FULL    = 3'd3,
    PERM_RSVD    = 3'd4,
    PERM_PRO     = 3'd5,
    PERM_RO      = 3'd6,
    PERM_RO_ALT  = 3'd7
  } perm_e;

  typedef struct packed {
    logic              xn;
    perm_e             perm;
    logic [ATTR_W-1:0] attr;
  } region_cfg_t;
endpackage

// File: rtl/mpu_region_match.sv
module mpu_region_match
  import mpu_chk_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              en_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [SRD_W-1:0]  srd_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  localparam int LG_W = SIZE_W + 1;

  logic [LG_W-1:0]   lg;
  logic              full;
  logic [ADDR_W:0]   span;
  logic [ADDR_W-1:0] lo_mask;
  logic              in_range;
  logic [ADDR_W-1:0] sub_sh;
  logic [2:0]        sub_idx;
  logic              sub_off;

  always_comb begin
    lg       = LG_W'(size_i) + LG_W'(1);
    full     = 32'(lg) >= ADDR_W;
    span     = (ADDR_W+1)'(1) << lg;
    lo_mask  = full ? '1 : (span[ADDR_W-1:0] - ADDR_W'(1));
    in_range = ((addr_i ^ base_i) & ~lo_mask) == '0;
    // eighth index: three bits just below the region size boundary
    sub_sh   = (addr_i & lo_mask) >> (lg - LG_W'(3));
    sub_idx  = sub_sh[2:0];
    sub_off  = (size_i >= SUBR_SIZE) && srd_i[sub_idx];
    hit_o    = en_i && (size_i >= MIN_SIZE) && in_range && !sub_off;
  end
endmodule

// File: rtl/mpu_prio_select.sv
module mpu_prio_select #(
  parameter int NUM_REGIONS = 8,
  localparam int IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  logic [NUM_REGIONS-1:0] hit_i,
  output logic [IDX_W-1:0]       idx_o,
  output logic                   any_o,
  output logic [NUM_REGIONS-1:0] win_oh_o
);
  // ascending scan, last hit wins: highest index has priority
  always_comb begin
    idx_o    = '0;
    any_o    = 1'b0;
    win_oh_o = '0;
    for (int i = 0; i < NUM_REGIONS; i++) begin
      if (hit_i[i]) begin
        idx_o    = IDX_W'(i);
        any_o    = 1'b1;
        win_oh_o = NUM_REGIONS'(1) << i;
      end
    end
  end
endmodule

// File: rtl/mpu_perm_decode.sv
module mpu_perm_decode
  import mpu_chk_pkg::*;
(
  input  perm_e perm_i,
  input  logic  xn_i,
  input  logic  priv_i,
  input  logic  write_i,
  input  logic  fetch_i,
  output logic  ok_o
);
  logic rd_ok, wr_ok;

  always_comb begin
    rd_ok = 1'b0;
    wr_ok = 1'b0;
    unique case (perm_i)
      PERM_PRW:              begin rd_ok = priv_i; wr_ok = priv_i; end
      PERM_PRW_URO:          begin rd_ok = 1'b1;   wr_ok = priv_i; end
      PERM_FULL:             begin rd_ok = 1'b1;   wr_ok = 1'b1;   end
      PERM_PRO:              begin rd_ok = priv_i; wr_ok = 1'b0;   end
      PERM_RO, PERM_RO_ALT:  begin rd_ok = 1'b1;   wr_ok = 1'b0;   end
      default:               begin rd_ok = 1'b0;   wr_ok = 1'b0;   end
    endcase
    // a fetch is a read, vetoed by execute-never
    ok_o = write_i ? wr_ok : (rd_ok && !(fetch_i && xn_i));
  end
endmodule

// File: rtl/mpu_access_check.sv
module mpu_access_check
  import mpu_chk_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  parameter int ADDR_W      = 32,
  localparam int IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          prot_en_i,
  input  logic                          bg_en_i,
  input  logic                          handler_en_i,
  input  logic [NUM_REGIONS-1:0]        region_en_i,
  input  logic [NUM_REGIONS*ADDR_W-1:0] region_base_i,
  input  logic [NUM_REGIONS*SIZE_W-1:0] region_size_i,
  input  logic [NUM_REGIONS*SRD_W-1:0]  region_srd_i,
  input  logic [NUM_REGIONS*PERM_W-1:0] region_perm_i,
  input  logic [NUM_REGIONS-1:0]        region_xn_i,
  input  logic [NUM_REGIONS*ATTR_W-1:0] region_attr_i,
  input  logic                          acc_valid_i,
  input  logic [ADDR_W-1:0]             acc_addr_i,
  input  logic                          acc_write_i,
  input  logic                          acc_fetch_i,
  input  logic                          acc_priv_i,
  input  logic                          acc_in_handler_i,
  output logic                          allow_o,
  output logic [IDX_W-1:0]              hit_idx_o,
  output logic                          no_hit_o,
  output logic [ATTR_W-1:0]             attr_o,
  output logic                          fault_o,
  output logic [IDX_W-1:0]              fault_idx_o,
  output logic                          fault_no_hit_o
);
  logic [NUM_REGIONS-1:0] region_hit;
  logic [NUM_REGIONS-1:0] win_oh;
  region_cfg_t            cfg_a [NUM_REGIONS];
  logic                   any_hit;
  region_cfg_t            sel_cfg;
  logic                   perm_ok;
  logic                   bypass;

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
    assign cfg_a[g].xn   = region_xn_i[g];
    assign cfg_a[g].perm = perm_e'(region_perm_i[g*PERM_W +: PERM_W]);
    assign cfg_a[g].attr = region_attr_i[g*ATTR_W +: ATTR_W];

    mpu_region_match #(.ADDR_W(ADDR_W)) u_match (
      .en_i   (region_en_i[g]),
      .base_i (region_base_i[g*ADDR_W +: ADDR_W]),
      .size_i (region_size_i[g*SIZE_W +: SIZE_W]),
      .srd_i  (region_srd_i[g*SRD_W +: SRD_W]),
      .addr_i (acc_addr_i),
      .hit_o  (region_hit[g])
    );
  end

  mpu_prio_select #(.NUM_REGIONS(NUM_REGIONS)) u_prio (
    .hit_i    (region_hit),
    .idx_o    (hit_idx_o),
    .any_o    (any_hit),
    .win_oh_o (win_oh)
  );

  assign sel_cfg  = any_hit ? cfg_a[hit_idx_o] : '0;
  assign attr_o   = sel_cfg.attr;
  assign no_hit_o = !any_hit;

  mpu_perm_decode u_perm (
    .perm_i  (sel_cfg.perm),
    .xn_i    (sel_cfg.xn),
    .priv_i  (acc_priv_i),
    .write_i (acc_write_i),
    .fetch_i (acc_fetch_i),
    .ok_o    (perm_ok)
  );

  assign bypass = acc_in_handler_i && !handler_en_i;

  always_comb begin
    if (!prot_en_i || bypass) allow_o = 1'b1;
    else if (any_hit)         allow_o = perm_ok;
    else                      allow_o = bg_en_i && acc_priv_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fault_o        <= 1'b0;
      fault_idx_o    <= '0;
      fault_no_hit_o <= 1'b0;
    end else begin
      fault_o <= acc_valid_i && !allow_o;
      if (acc_valid_i && !allow_o) begin
        fault_idx_o    <= hit_idx_o;
        fault_no_hit_o <= !any_hit;
      end
    end
  end

  AST_ONE_WINNER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(win_oh)); // R6
  AST_WINNER_MATCHES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_hit |-> region_hit[hit_idx_o]); // R6
  AST_OFF_ALLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prot_en_i |-> allow_o); // R8
  AST_HANDLER_BYPASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_in_handler_i && !handler_en_i) |-> allow_o); // R9
  AST_UNPRIV_NO_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prot_en_i && !bypass && no_hit_o && !acc_priv_i) |-> !allow_o); // R7
  AST_XN_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prot_en_i && !bypass && !no_hit_o && acc_fetch_i && !acc_write_i && sel_cfg.xn) |-> !allow_o); // R5
  AST_FAULT_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && !allow_o) |=> fault_o); // R10
  AST_FAULT_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> $past(acc_valid_i)); // R10
endmodule

// File: tb/mpu_access_check_bench.sv
`timescale 1ns/1ps
module mpu_access_check_bench;
  localparam int N  = 8;
  localparam int AW = 32;

  typedef struct packed {
    logic [31:0] addr;
    logic wr, fx, pv, inh, prot, bg, hen;
    logic allow, nohit;
    logic [2:0] idx;
    logic [3:0] req;
  } vec_t;

  // addr wr fx pv inh prot bg hen | allow nohit idx | req
  localparam int NV = 28;
  localparam vec_t VECS [NV] = '{
    '{32'h2000_0010,0,0,0,0,1,0,0, 1,0,3'd0, 4'd1},  // R1 inside r0
    '{32'h2000_FFFC,0+1,0,0,0,1,0,0, 1,0,3'd0, 4'd1},// R1 top word of r0
    '{32'h2001_0000,0,0,1,0,1,0,0, 0,1,3'd0, 4'd1},  // R1 just past r0
    '{32'h2000_4800,1,0,0,0,1,0,0, 0,0,3'd1, 4'd6},  // R6 r1 overrides r0
    '{32'h2000_4800,1,0,1,0,1,0,0, 1,0,3'd1, 4'd4},  // R4 code 1 priv write
    '{32'h2000_5000,0,0,0,0,1,0,0, 1,0,3'd0, 4'd6},  // R6 past r1, back to r0
    '{32'h0800_0100,0,0,0,0,1,0,0, 1,0,3'd2, 4'd4},  // R4 code 6 read
    '{32'h0800_0100,1,0,1,0,1,0,0, 0,0,3'd2, 4'd4},  // R4 code 6 write
    '{32'h0801_0004,0,0,1,0,1,0,0, 0,1,3'd0, 4'd3},  // R3 eighth 2 disabled
    '{32'h0801_8000,0,0,1,0,1,0,0, 1,0,3'd2, 4'd3},  // R3 eighth 3 enabled
    '{32'h4000_0004,0,1,1,0,1,0,0, 0,0,3'd3, 4'd5},  // R5 fetch from xn region
    '{32'h4000_0004,0,0,0,0,1,0,0, 1,0,3'd3, 4'd4},  // R4 code 2 unpriv read
    '{32'h4000_0004,1,0,0,0,1,0,0, 0,0,3'd3, 4'd4},  // R4 code 2 unpriv write
    '{32'h6000_0040,0,0,1,0,1,0,0, 1,0,3'd4, 4'd3},  // R3 mask ignored at 128 B
    '{32'h6000_0040,0,0,0,0,1,0,0, 0,0,3'd4, 4'd4},  // R4 code 5 unpriv read
    '{32'h6000_0040,1,0,1,0,1,0,0, 0,0,3'd4, 4'd4},  // R4 code 5 priv write
    '{32'h7000_0000,0,0,1,0,1,0,0, 0,1,3'd0, 4'd2},  // R2 SIZE 3 never hits
    '{32'h5000_0010,0,0,1,0,1,0,0, 0,0,3'd6, 4'd4},  // R4 code 4 no access
    '{32'h5000_0020,0,0,1,0,1,0,0, 0,1,3'd0, 4'd1},  // R1 past 32 B region
    '{32'h9000_0000,0,0,1,0,1,1,0, 1,1,3'd0, 4'd7},  // R7 bg priv allowed
    '{32'h9000_0000,0,0,0,0,1,1,0, 0,1,3'd0, 4'd7},  // R7 bg unpriv denied
    '{32'h2000_4800,1,0,0,0,1,1,0, 0,0,3'd1, 4'd7},  // R7 region beats bg
    '{32'h5000_0010,0,0,1,0,0,0,0, 1,0,3'd6, 4'd8},  // R8 protection off
    '{32'h9000_0000,1,0,0,0,0,0,0, 1,1,3'd0, 4'd8},  // R8 off, no hit
    '{32'h5000_0010,0,0,1,1,1,0,0, 1,0,3'd6, 4'd9},  // R9 handler bypass
    '{32'h5000_0010,0,0,1,1,1,0,1, 0,0,3'd6, 4'd9},  // R9 handler checked
    '{32'h4000_0000,0,1,1,1,1,0,0, 1,0,3'd3, 4'd9},  // R9 bypass beats xn
    '{32'h0800_0000,0,1,0,0,1,0,0, 1,0,3'd2, 4'd5}   // R5 fetch as read, no xn
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic prot_en, bg_en, handler_en;
  logic [N-1:0]    r_en, r_xn;
  logic [N*AW-1:0] r_base;
  logic [N*5-1:0]  r_size;
  logic [N*8-1:0]  r_srd;
  logic [N*3-1:0]  r_perm;
  logic [N*6-1:0]  r_attr;
  logic            valid, wr, fx, pv, inh;
  logic [AW-1:0]   addr;
  logic            allow, no_hit, fault, fault_nh;
  logic [2:0]      hit_idx, fault_idx;
  logic [5:0]      attr;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  mpu_access_check u_mpu_access_check (
    .clk_i(clk), .rst_ni(rst_n),
    .prot_en_i(prot_en), .bg_en_i(bg_en), .handler_en_i(handler_en),
    .region_en_i(r_en), .region_base_i(r_base), .region_size_i(r_size),
    .region_srd_i(r_srd), .region_perm_i(r_perm), .region_xn_i(r_xn),
    .region_attr_i(r_attr),
    .acc_valid_i(valid), .acc_addr_i(addr), .acc_write_i(wr),
    .acc_fetch_i(fx), .acc_priv_i(pv), .acc_in_handler_i(inh),
    .allow_o(allow), .hit_idx_o(hit_idx), .no_hit_o(no_hit), .attr_o(attr),
    .fault_o(fault), .fault_idx_o(fault_idx), .fault_no_hit_o(fault_nh)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic set_region(input int i, input bit en, input logic [31:0] base,
                            input logic [4:0] size, input logic [7:0] srd,
                            input logic [2:0] perm, input bit xn);
    r_en[i]         = en;
    r_base[i*AW +: AW] = base;
    r_size[i*5 +: 5] = size;
    r_srd[i*8 +: 8]  = srd;
    r_perm[i*3 +: 3] = perm;
    r_xn[i]         = xn;
    r_attr[i*6 +: 6] = 6'(i + 1);
  endtask

  task automatic drive(input vec_t v, input bit vld);
    @(negedge clk);
    valid = vld; addr = v.addr; wr = v.wr; fx = v.fx; pv = v.pv; inh = v.inh;
    prot_en = v.prot; bg_en = v.bg; handler_en = v.hen;
    #1;
  endtask

  task automatic run_vec(input vec_t v);
    string rq;
    rq = $sformatf("R%0d", v.req);
    drive(v, 1'b1);
    chk(allow == v.allow, rq, "allow", 32'(allow), 32'(v.allow));
    chk(no_hit == v.nohit, rq, "no_hit", 32'(no_hit), 32'(v.nohit));
    chk(hit_idx == v.idx, rq, "hit_idx", 32'(hit_idx), 32'(v.idx));
    chk(attr == (v.nohit ? 6'd0 : 6'(v.idx + 1)), "R6", "attr", 32'(attr),
        32'(v.nohit ? 0 : v.idx + 1));
    @(posedge clk); #1;
    chk(fault == !v.allow, "R10", "fault", 32'(fault), 32'(!v.allow));
    if (!v.allow) begin
      chk(fault_idx == v.idx, "R10", "fault_idx", 32'(fault_idx), 32'(v.idx));
      chk(fault_nh == v.nohit, "R10", "fault_no_hit", 32'(fault_nh), 32'(v.nohit));
    end
  endtask

  initial begin
    #500000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    vec_t v;
    valid = 0; addr = '0; wr = 0; fx = 0; pv = 0; inh = 0;
    prot_en = 1; bg_en = 0; handler_en = 0;
    r_en = '0; r_xn = '0; r_base = '0; r_size = '0; r_srd = '0; r_perm = '0; r_attr = '0;
    set_region(0, 1, 32'h2000_0000, 5'd15, 8'h00, 3'd3, 0);
    set_region(1, 1, 32'h2000_4000, 5'd11, 8'h00, 3'd1, 0);
    set_region(2, 1, 32'h0800_0000, 5'd17, 8'h04, 3'd6, 0);
    set_region(3, 1, 32'h4000_0000, 5'd9,  8'h00, 3'd2, 1);
    set_region(4, 1, 32'h6000_0000, 5'd6,  8'hFF, 3'd5, 0);
    set_region(5, 1, 32'h7000_0000, 5'd3,  8'h00, 3'd3, 0);
    set_region(6, 1, 32'h5000_0000, 5'd4,  8'h00, 3'd4, 0);
    set_region(7, 0, 32'h2000_0000, 5'd15, 8'h00, 3'd0, 0);

    // R11 reset state
    #12;
    chk(fault == 0, "R11", "fault in reset", 32'(fault), 0);
    chk(fault_idx == 0, "R11", "fault_idx in reset", 32'(fault_idx), 0);
    chk(fault_nh == 0, "R11", "fault_no_hit in reset", 32'(fault_nh), 0);
    @(negedge clk); rst_n = 1;

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R10 denied access without strobe: no fault, captured fields hold
    v = VECS[2];
    drive(v, 1'b0);
    @(posedge clk); #1;
    chk(fault == 0, "R10", "fault without strobe", 32'(fault), 0);
    chk(fault_idx == 3'd6, "R10", "fault_idx held", 32'(fault_idx), 6);
    chk(fault_nh == 0, "R10", "fault_no_hit held", 32'(fault_nh), 0);

    // R10 fault is a single-cycle pulse
    drive(v, 1'b1);
    @(posedge clk); #1;
    chk(fault == 1, "R10", "fault pulse", 32'(fault), 1);
    drive(VECS[0], 1'b0);
    @(posedge clk); #1;
    chk(fault == 0, "R10", "fault pulse ends", 32'(fault), 0);
    chk(fault_nh == 1, "R10", "fault_no_hit held", 32'(fault_nh), 1);

    // R1 R6 full-space region in top slot, base ignored
    @(negedge clk);
    set_region(7, 1, 32'hDEAD_0000, 5'd31, 8'h00, 3'd3, 0);
    v = VECS[3];
    drive(v, 1'b1);
    chk(allow == 1, "R6", "slot 7 overrides r1", 32'(allow), 1);
    chk(hit_idx == 3'd7, "R6", "slot 7 index", 32'(hit_idx), 7);
    chk(attr == 6'd8, "R6", "slot 7 attr", 32'(attr), 8);
    v.addr = 32'hF000_0000;
    drive(v, 1'b1);
    chk(no_hit == 0, "R1", "SIZE 31 covers all", 32'(no_hit), 0);
    chk(hit_idx == 3'd7, "R1", "SIZE 31 index", 32'(hit_idx), 7);
    // R3 mask applies to a full-space region: eighth 7 disabled
    @(negedge clk);
    set_region(7, 1, 32'h0000_0000, 5'd31, 8'h80, 3'd3, 0);
    #1;
    chk(no_hit == 1, "R3", "eighth 7 of 4 GB off", 32'(no_hit), 1);
    @(negedge clk);
    set_region(7, 0, 32'h2000_0000, 5'd15, 8'h00, 3'd0, 0);
    valid = 0;
    @(posedge clk); #1;

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule